// File: doc/BRIEF.md
# Three-Wire Serial Register Bank

This block is a slave port that gives a host processor read and write access to a bank of 8-bit registers over three wires. The wires are an active-low frame enable, a clock driven by the host, and one data line that both ends share. Each frame starts with a direction bit, where 0 requests a write and 1 requests a read. A 7-bit register address follows, then a single data byte. All fields are sent most significant bit first. On a write the host shifts the byte in. On a read the slave takes over the data line partway through the frame and shifts the byte back out.

The serial wires are sampled by a faster system clock. Each wire passes through a synchronizer, and the edges of the serial clock are detected in the system clock domain. The bank holds a parameterized number of read/write configuration registers at the bottom of the address space, which drive a flat output bus. A group of read-only status registers starts at a configurable base address and is fed from external inputs. No other address is implemented. The shared data line is brought out as separate input, output and output-enable signals, so a pad cell at chip level can join them.

Top module: `sio_regbank`

## Requirements
- R1: After reset every configuration register holds 0x00 and the data output enable is low.
- R2: A frame whose direction bit is 0 carries a 7-bit address and an 8-bit data byte, both MSB first and sampled on the rising serial clock edge. After the 16th bit, the configuration register at that address takes the byte.
- R3: In a frame whose direction bit is 1, the output enable rises on the falling serial clock edge that follows the 7th address bit. The addressed register is then driven MSB first, with a new bit after each following falling edge.
- R4: The output enable stays low throughout write frames and whenever the frame enable is high. When the enable deasserts, the output enable falls.
- R5: If the frame enable deasserts before the 16th rising edge of a write frame, no register changes and the next frame starts from its direction bit.
- R6: A write to a status address is ignored, and reading that address still returns the status input.
- R7: A read of an address that has neither a configuration nor a status register returns 0x00, and a write to such an address changes no register.
- R8: Status register k sits at address STAT_BASE+k. A read returns status input byte k, sampled at the falling edge where driving begins.
- R9: Serial clock edges after the 16th in a frame are ignored. Only one register is written per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial wires |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sen_ni | input | 1 | Frame enable, active low |
| sclk_i | input | 1 | Serial clock from the host |
| sdio_i | input | 1 | Data line as seen from the pad |
| sdio_o | output | 1 | Data driven back to the host on reads |
| sdio_oe_o | output | 1 | Output enable for the data pad |
| status_i | input | NUM_STAT*8 | Status bytes, byte k at bits 8k+7:8k |
| cfg_o | output | NUM_CFG*8 | Configuration registers, register k at bits 8k+7:8k |

## Verification
The assertions assume that each serial clock level lasts longer than the synchronizer latency plus one register, so the system clock sees every serial edge on its own. They also assume that the frame enable and the data line only change while the serial clock is low, well clear of a rising edge. The stimulus holds each serial clock phase for six system cycles. It changes data and enable only in the low phase, and changes the status inputs only between frames. Under these conditions a rising edge, a falling edge and an enable change never fall in the same system cycle.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int ADDR_W     = 7;
  localparam int DATA_W     = 8;
  localparam int HDR_BITS   = 1 + ADDR_W;
  localparam int FRAME_BITS = HDR_BITS + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
  parameter int               STAGES  = 2,
  parameter int               WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sio_frame.sv
module sio_frame
  import sio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sen_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              wr_o,
  output logic              sdo_o,
  output logic              oe_o
);
  logic              sclk_q, rise, fall;
  logic [CNT_W-1:0]  cnt_q;
  logic [HDR_BITS-2:0] rx_q;
  logic [HDR_BITS-1:0] rx_n;
  logic              dir_q, oe_q, wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, tx_q;

  assign rise = sclk_i & ~sclk_q;
  assign fall = ~sclk_i & sclk_q;
  assign rx_n = {rx_q, sdi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b0;
      cnt_q   <= '0;
      rx_q    <= '0;
      dir_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      oe_q    <= 1'b0;
      tx_q    <= '0;
    end else begin
      sclk_q <= sclk_i;
      wr_q   <= 1'b0;
      if (sen_ni) begin
        // idle or abort: drop partial frame
        cnt_q <= '0;
        oe_q  <= 1'b0;
      end else begin
        if (rise && cnt_q < CNT_W'(FRAME_BITS)) begin
          cnt_q <= cnt_q + 1'b1;
          rx_q  <= rx_n[HDR_BITS-2:0];
          if (cnt_q == CNT_W'(HDR_BITS - 1)) begin
            dir_q  <= rx_n[HDR_BITS-1];
            addr_q <= rx_n[ADDR_W-1:0];
          end
          if (cnt_q == CNT_W'(FRAME_BITS - 1) && !dir_q) begin
            wdata_q <= rx_n[DATA_W-1:0];
            wr_q    <= 1'b1;
          end
        end
        if (fall) begin
          if (oe_q) begin
            tx_q <= {tx_q[DATA_W-2:0], 1'b0};
          end else if (dir_q && cnt_q == CNT_W'(HDR_BITS)) begin
            tx_q <= rdata_i;
            oe_q <= 1'b1;
          end
        end
      end
    end
  end

  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign wr_o    = wr_q;
  assign sdo_o   = tx_q[DATA_W-1];
  assign oe_o    = oe_q;

  // R4
  sen_high_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sen_ni |=> !oe_q);
  // R5
  abort_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sen_ni |=> cnt_q == '0);
  // R2
  wr_at_frame_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_q |-> (cnt_q == CNT_W'(FRAME_BITS)) && !dir_q);
  // R3
  drive_only_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |-> dir_q && (cnt_q >= CNT_W'(HDR_BITS)));
  // R9
  single_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_q |=> !wr_q);
endmodule

// File: rtl/sio_regfile.sv
module sio_regfile
  import sio_pkg::*;
#(
  parameter int NUM_CFG   = 16,
  parameter int NUM_STAT  = 4,
  parameter int STAT_BASE = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic [NUM_STAT*DATA_W-1:0] status_i,
  output logic [DATA_W-1:0]          rdata_o,
  output logic [NUM_CFG*DATA_W-1:0]  cfg_o
);
  logic [DATA_W-1:0] cfg_q [NUM_CFG];

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               cfg_q[g] <= '0;
      else if (wr_i && addr_i == ADDR_W'(g))     cfg_q[g] <= wdata_i;
    end
    assign cfg_o[g*DATA_W +: DATA_W] = cfg_q[g];
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_CFG; i++)
      if (addr_i == ADDR_W'(i)) rdata_o = cfg_q[i];
    for (int j = 0; j < NUM_STAT; j++)
      if (addr_i == ADDR_W'(STAT_BASE + j)) rdata_o = status_i[j*DATA_W +: DATA_W];
  end

  // R6
  no_cfg_write_above_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i >= ADDR_W'(NUM_CFG)) |=> $stable(cfg_o));
endmodule

// File: rtl/sio_regbank.sv
module sio_regbank
  import sio_pkg::*;
#(
  parameter int NUM_CFG     = 16,
  parameter int NUM_STAT    = 4,
  parameter int STAT_BASE   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sen_ni,
  input  logic                       sclk_i,
  input  logic                       sdio_i,
  output logic                       sdio_o,
  output logic                       sdio_oe_o,
  input  logic [NUM_STAT*DATA_W-1:0] status_i,
  output logic [NUM_CFG*DATA_W-1:0]  cfg_o
);
  logic              sen_s, sclk_s, sdi_s;
  logic              wr;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata, rdata;

  sio_sync #(.STAGES(SYNC_STAGES), .WIDTH(3), .RST_VAL(3'b100)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sen_ni, sclk_i, sdio_i}),
    .q_o    ({sen_s, sclk_s, sdi_s})
  );

  sio_frame u_frame (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sen_ni  (sen_s),
    .sclk_i  (sclk_s),
    .sdi_i   (sdi_s),
    .rdata_i (rdata),
    .addr_o  (addr),
    .wdata_o (wdata),
    .wr_o    (wr),
    .sdo_o   (sdio_o),
    .oe_o    (sdio_oe_o)
  );

  sio_regfile #(.NUM_CFG(NUM_CFG), .NUM_STAT(NUM_STAT), .STAT_BASE(STAT_BASE)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr),
    .addr_i   (addr),
    .wdata_i  (wdata),
    .status_i (status_i),
    .rdata_o  (rdata),
    .cfg_o    (cfg_o)
  );
endmodule

// File: tb/sio_regbank_tb.sv
module sio_regbank_tb;
  localparam int NC = 16, NS = 4, SB = 32, HALF = 6;

  logic clk = 0, rst_n = 0, sen_n = 1, sclk = 0, sdi = 0;
  logic sdo, oe;
  logic [NS*8-1:0] stat = '0;
  logic [NC*8-1:0] cfg;
  logic [7:0] mdl [NC];
  logic [7:0] exp_q[$], act_q[$];
  string tag_q[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sio_regbank #(.NUM_CFG(NC), .NUM_STAT(NS), .STAT_BASE(SB)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sen_ni(sen_n), .sclk_i(sclk), .sdio_i(sdi),
    .sdio_o(sdo), .sdio_oe_o(oe), .status_i(stat), .cfg_o(cfg));

  task automatic chk(input logic [127:0] act, input logic [127:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] mdl_flat();
    logic [127:0] f = '0;
    for (int i = 0; i < NC; i++) f[i*8 +: 8] = mdl[i];
    return f;
  endfunction

  task automatic xfer(input logic dir, input logic [6:0] a, input logic [7:0] d,
                      input int nbits, output logic [7:0] rd);
    logic [15:0] w;
    w = {dir, a, d};
    rd = '0;
    @(negedge clk); sen_n = 0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 16) ? w[15-i] : 1'b1;
      repeat (HALF) @(negedge clk);
      if (dir && i >= 8 && i < 16) begin
        chk(128'(oe), 128'(1), "R3 oe during read data");
        rd = {rd[6:0], sdo};
      end else if (i < 8 || !dir) begin
        chk(128'(oe), 128'(0), "R4 oe low outside read data");
      end
      sclk = 1; repeat (HALF) @(negedge clk); sclk = 0;
    end
    repeat (HALF) @(negedge clk); sen_n = 1;
    repeat (2*HALF) @(negedge clk);
    chk(128'(oe), 128'(0), "R4 oe low after enable high");
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d, input int nbits);
    logic [7:0] dummy;
    xfer(1'b0, a, d, nbits, dummy);
    if (nbits >= 16 && a < NC) mdl[a] = d;
  endtask

  task automatic rd(input logic [6:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] got;
    exp_q.push_back(exp); tag_q.push_back(tag);
    xfer(1'b1, a, 8'h00, 16, got);
    act_q.push_back(got);
  endtask

  // monitor: pop and compare read results
  always @(negedge clk) begin
    if (act_q.size() > 0) begin
      logic [7:0] a_v, e_v;
      string t_v;
      a_v = act_q.pop_front(); e_v = exp_q.pop_front(); t_v = tag_q.pop_front();
      chk(128'(a_v), 128'(e_v), t_v);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NC; i++) mdl[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(128'(cfg), 128'(0), "R1 cfg reset");
    chk(128'(oe), 128'(0), "R1 oe reset");

    wr(7'd3, 8'hA5, 16);  chk(128'(cfg), mdl_flat(), "R2 write addr 3");
    wr(7'd15, 8'h3C, 16); chk(128'(cfg), mdl_flat(), "R2 write addr 15");
    wr(7'd0, 8'h81, 16);  chk(128'(cfg), mdl_flat(), "R2 write addr 0");
    rd(7'd3, 8'hA5, "R3 read addr 3");
    rd(7'd15, 8'h3C, "R3 read addr 15");
    rd(7'd0, 8'h81, "R3 read addr 0");

    stat = 32'h4D_C3_7E_12;
    rd(7'(SB), 8'h12, "R8 status 0");
    rd(7'(SB+3), 8'h4D, "R8 status 3");
    stat[15:8] = 8'h99;
    rd(7'(SB+1), 8'h99, "R8 status 1 updated");

    wr(7'(SB+2), 8'hFF, 16);
    chk(128'(cfg), mdl_flat(), "R6 status write ignored cfg");
    rd(7'(SB+2), 8'hC3, "R6 status read after write");

    rd(7'd20, 8'h00, "R7 unimplemented 20");
    rd(7'd127, 8'h00, "R7 unimplemented 127");
    wr(7'd20, 8'h55, 16);
    chk(128'(cfg), mdl_flat(), "R7 unimplemented write");

    wr(7'd5, 8'h77, 12);
    chk(128'(cfg), mdl_flat(), "R5 abort after 12 bits");
    wr(7'd5, 8'h66, 15);
    chk(128'(cfg), mdl_flat(), "R5 abort after 15 bits");
    wr(7'd5, 8'h5A, 16);
    chk(128'(cfg), mdl_flat(), "R5 full write after abort");
    rd(7'd5, 8'h5A, "R5 readback");

    wr(7'd6, 8'h11, 24);
    chk(128'(cfg), mdl_flat(), "R9 extra clocks ignored");
    rd(7'd6, 8'h11, "R9 readback");

    repeat (4) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule